// File: doc/BRIEF.md
# Multicart Outer CHR Bank Composer

This block builds the character-memory address seen by the picture processor in a multicart cartridge mapper. An inner bank-switching mapper supplies an 8-bit index that selects a 1 KiB CHR bank. This block combines that index with a CPU-written outer base and three bits of a mode register. The result is CHR A20..A10, plus a line that chooses between the ROM chip and the RAM chip.

One mode bit changes how the low three address lines are driven. When it is clear they come from the inner mapper's bank index. When it is set, PPU A12..A10 pass straight through and the CPU-written base fills the upper lines. A build-time option adds a 2-bit latch for discrete-logic style 8 KiB switching below the outer base. The CPU loads this latch by writing anywhere in the upper half of its address space.

The mode register and the base register are written through a CPU write port. A register is selected when the write address matches a fixed mask, and one address bit chosen by a parameter must be set. The address output is purely combinational from the PPU lines, the inner index and the stored registers.

Top module: `chr_outer_bank`

## Requirements
- R1: After a synchronous reset, the mode register, the base register and the latch are all zero. In that state `chr_addr` equals the inner bank index zero-extended, and `chr_ram_sel` is 0.
- R2: A CPU write lands in a register only if `(wr_addr & M) == (16'h5000 | 1<<SEL_BIT)`, where `M = 16'hF003 | 1<<SEL_BIT`. Address bits [1:0] = 0 select the mode register, and only data bits 6, 5 and 4 are kept. Bits [1:0] = 2 select the base register, and all 8 bits are kept. Every other write leaves both registers unchanged.
- R3: With mode bit 6 = 0 and mode bit 4 = 0, `chr_addr[10:8]` = base[7:5] and `chr_addr[7:0]` = the inner index.
- R4: With mode bit 6 = 0 and mode bit 4 = 1, `chr_addr[10:7]` = base[7:4] and `chr_addr[6:0]` = inner index bits [6:0].
- R5: With mode bit 6 = 1, `chr_addr[2:0]` = `ppu_a`. Here `ppu_a` is PPU A12..A10, and `chr_addr` bit 0 is CHR A10.
- R6: With mode bit 6 = 1 and the latch not active, `chr_addr[10:3]` = base[7:0]. The latch is not active when LATCH_EN = 0 or when mode bit 5 = 1.
- R7: With LATCH_EN = 1, mode bit 6 = 1, mode bit 5 = 0 and mode bit 4 = 0, `chr_addr[10:5]` = base[7:2] and `chr_addr[4:3]` = latch[1:0].
- R8: Under the same conditions as R7 but with mode bit 4 = 1, `chr_addr[10:4]` = base[7:1] and `chr_addr[3]` = latch[0].
- R9: A CPU write with `wr_addr[15]` = 1 loads `wr_data[1:0]` into the latch only while the latch is active (LATCH_EN = 1, mode bit 6 = 1, mode bit 5 = 0). At all other times the latch holds its value.
- R10: `chr_ram_sel` follows mode bit 5 when LATCH_EN = 0. When LATCH_EN = 1 it equals mode bit 5 AND NOT mode bit 6.
- R11: `chr_addr` follows changes on `inner_bank` and `ppu_a` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| inner_bank | input | 8 | 1 KiB CHR bank index from the inner mapper |
| ppu_a | input | 3 | PPU address lines A12..A10 |
| chr_addr | output | 11 | CHR address lines A20..A10 |
| chr_ram_sel | output | 1 | 1 selects the CHR RAM chip, 0 the CHR ROM chip |

## Verification
The bench builds two instances side by side, both with SEL_BIT = 4. One has LATCH_EN = 1 and the other has LATCH_EN = 0, and both receive the same CPU writes and PPU stimulus. Because of this, one write of mode bit 5 shows both meanings of that bit at once: latch gating in the first instance and chip selection in the second. The latch-gating rule of R9 is exercised in both directions. Upper-half writes are issued while the latch is inactive, and the old latch value is read back through the address once the latch becomes active again.

// File: rtl/chr_outer_pkg.sv
package chr_outer_pkg;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int BANK_W  = 8;
    localparam int PPU_W   = 3;
    localparam int BASE_W  = 8;
    localparam int LATCH_W = 2;
    localparam int OUT_W   = PPU_W + BASE_W;

    // Mode register bits that matter on the CHR side (data bits 6,5,4)
    typedef struct packed {
        logic ppu_direct;   // bit 6: low lines from PPU
        logic alt_sel;      // bit 5: RAM select or latch disable
        logic half_outer;   // bit 4: smaller outer window
    } chr_mode_t;

    typedef enum logic [2:0] {
        SRC_INNER_WIDE,
        SRC_INNER_NARROW,
        SRC_DIRECT_FULL,
        SRC_DIRECT_LATCH2,
        SRC_DIRECT_LATCH1
    } chr_src_t;

    function automatic logic latch_live(chr_mode_t m, bit has_latch);
        return has_latch && m.ppu_direct && !m.alt_sel;
    endfunction

    function automatic chr_src_t pick_src(chr_mode_t m, bit has_latch);
        chr_src_t s;
        if (!m.ppu_direct)
            s = m.half_outer ? SRC_INNER_NARROW : SRC_INNER_WIDE;
        else if (!latch_live(m, has_latch))
            s = SRC_DIRECT_FULL;
        else
            s = m.half_outer ? SRC_DIRECT_LATCH1 : SRC_DIRECT_LATCH2;
        return s;
    endfunction

    function automatic logic [OUT_W-1:0] compose(
        chr_src_t              s,
        logic [BASE_W-1:0]     base,
        logic [BANK_W-1:0]     inner,
        logic [PPU_W-1:0]      ppu,
        logic [LATCH_W-1:0]    lat
    );
        logic [OUT_W-1:0] a;
        unique case (s)
            SRC_INNER_WIDE:    a = {base[7:5], inner[7:0]};
            SRC_INNER_NARROW:  a = {base[7:4], inner[6:0]};
            SRC_DIRECT_LATCH2: a = {base[7:2], lat[1:0], ppu};
            SRC_DIRECT_LATCH1: a = {base[7:1], lat[0], ppu};
            default:           a = {base, ppu};
        endcase
        return a;
    endfunction

endpackage

// File: rtl/chr_outer_regs.sv
module chr_outer_regs
    import chr_outer_pkg::*;
#(
    parameter int SEL_BIT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output chr_mode_t         mode_q,
    output logic [BASE_W-1:0] base_q
);
    localparam logic [ADDR_W-1:0] SEL_ONE   = ADDR_W'(1) << SEL_BIT;
    localparam logic [ADDR_W-1:0] DEC_MASK  = 16'hF003 | SEL_ONE;
    localparam logic [ADDR_W-1:0] MODE_HIT  = 16'h5000 | SEL_ONE;
    localparam logic [ADDR_W-1:0] BASE_HIT  = 16'h5002 | SEL_ONE;

    logic mode_we, base_we;

    assign mode_we = wr_en && ((wr_addr & DEC_MASK) == MODE_HIT);
    assign base_we = wr_en && ((wr_addr & DEC_MASK) == BASE_HIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            base_q <= '0;
        end else begin
            if (mode_we) mode_q <= chr_mode_t'(wr_data[6:4]);
            if (base_we) base_q <= wr_data;
        end
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr[15:12] == 4'h5 && wr_addr[1:0] == 2'd0) |=> $stable(mode_q)); // R2
    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr[15:12] == 4'h5 && wr_addr[1:0] == 2'd2) |=> $stable(base_q)); // R2

endmodule

// File: rtl/chr_outer_latch.sv
module chr_outer_latch
    import chr_outer_pkg::*;
#(
    parameter bit LATCH_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_hi,
    input  logic [LATCH_W-1:0] wr_bits,
    input  chr_mode_t          mode_q,
    output logic [LATCH_W-1:0] lat_q
);
    generate
        if (LATCH_EN) begin : g_latch
            logic live;
            assign live = latch_live(mode_q, 1'b1);
            always_ff @(posedge clk) begin
                if (rst)
                    lat_q <= '0;
                else if (wr_en && wr_hi && live)
                    lat_q <= wr_bits;
            end

            AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
                !(wr_en && wr_hi && mode_q.ppu_direct && !mode_q.alt_sel)
                |=> $stable(lat_q)); // R9
        end else begin : g_none
            assign lat_q = '0;
        end
    endgenerate

endmodule

// File: rtl/chr_outer_mux.sv
module chr_outer_mux
    import chr_outer_pkg::*;
#(
    parameter bit LATCH_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  chr_mode_t          mode_q,
    input  logic [BASE_W-1:0]  base_q,
    input  logic [LATCH_W-1:0] lat_q,
    input  logic [BANK_W-1:0]  inner_bank,
    input  logic [PPU_W-1:0]   ppu_a,
    output logic [OUT_W-1:0]   chr_addr,
    output logic               chr_ram_sel
);
    chr_src_t src;

    always_comb begin
        src      = pick_src(mode_q, LATCH_EN);
        chr_addr = compose(src, base_q, inner_bank, ppu_a, lat_q);
    end

    generate
        if (LATCH_EN) begin : g_sel_latch
            assign chr_ram_sel = mode_q.alt_sel && !mode_q.ppu_direct;
        end else begin : g_sel_plain
            assign chr_ram_sel = mode_q.alt_sel;
        end
    endgenerate

    AST_DIRECT_LOW: assert property (@(posedge clk) disable iff (rst)
        mode_q.ppu_direct |-> chr_addr[2:0] == ppu_a); // R5
    AST_INNER_LOW: assert property (@(posedge clk) disable iff (rst)
        (!mode_q.ppu_direct && !mode_q.half_outer) |-> chr_addr[7:0] == inner_bank); // R3
    AST_DIRECT_ROM: assert property (@(posedge clk) disable iff (rst)
        (LATCH_EN && mode_q.ppu_direct) |-> !chr_ram_sel); // R10

endmodule

// File: rtl/chr_outer_bank.sv
module chr_outer_bank
    import chr_outer_pkg::*;
#(
    parameter int SEL_BIT  = 4,
    parameter bit LATCH_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [15:0]        wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [7:0]         inner_bank,
    input  logic [2:0]         ppu_a,
    output logic [10:0]        chr_addr,
    output logic               chr_ram_sel
);
    chr_mode_t          mode_q;
    logic [BASE_W-1:0]  base_q;
    logic [LATCH_W-1:0] lat_q;

    chr_outer_regs #(.SEL_BIT(SEL_BIT)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode_q(mode_q), .base_q(base_q)
    );

    chr_outer_latch #(.LATCH_EN(LATCH_EN)) u_latch (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_hi(wr_addr[15]),
        .wr_bits(wr_data[LATCH_W-1:0]), .mode_q(mode_q), .lat_q(lat_q)
    );

    chr_outer_mux #(.LATCH_EN(LATCH_EN)) u_mux (
        .clk(clk), .rst(rst), .mode_q(mode_q), .base_q(base_q),
        .lat_q(lat_q), .inner_bank(inner_bank), .ppu_a(ppu_a),
        .chr_addr(chr_addr), .chr_ram_sel(chr_ram_sel)
    );

    AST_RESET_CLEAN: assert property (@(posedge clk)
        rst |=> (chr_addr == {3'b000, inner_bank} && !chr_ram_sel)); // R1

endmodule

// File: tb/chr_outer_bank_bench.sv
module chr_outer_bank_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  inner_bank = '0;
    logic [2:0]  ppu_a = '0;
    logic [10:0] addr_l, addr_n;
    logic        ram_l, ram_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference state (behavioural)
    int m_mode = 0, m_base = 0, m_lat = 0;

    always #5 clk = ~clk;

    chr_outer_bank #(.SEL_BIT(4), .LATCH_EN(1'b1)) u_chr_outer_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .inner_bank(inner_bank), .ppu_a(ppu_a), .chr_addr(addr_l), .chr_ram_sel(ram_l)
    );

    chr_outer_bank #(.SEL_BIT(4), .LATCH_EN(1'b0)) u_chr_outer_bank_nolatch (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .inner_bank(inner_bank), .ppu_a(ppu_a), .chr_addr(addr_n), .chr_ram_sel(ram_n)
    );

    function automatic int bitof(int v, int b);
        return (v >> b) % 2;
    endfunction

    function automatic int exp_addr(int mode, int base, int inner, int ppu, int lat, int le);
        if (bitof(mode, 6) == 0) begin
            if (bitof(mode, 4) == 0) return (base / 32) * 256 + inner;
            return (base / 16) * 128 + inner % 128;
        end
        if (le == 1 && bitof(mode, 5) == 0) begin
            if (bitof(mode, 4) == 0) return ((base / 4) * 4 + lat) * 8 + ppu;
            return ((base / 2) * 2 + lat % 2) * 8 + ppu;
        end
        return base * 8 + ppu;
    endfunction

    function automatic int exp_ram(int mode, int le);
        if (le == 1) return (bitof(mode, 5) == 1 && bitof(mode, 6) == 0) ? 1 : 0;
        return bitof(mode, 5);
    endfunction

    function automatic string tag_of(int mode, int le);
        if (bitof(mode, 6) == 0) return bitof(mode, 4) ? "R4" : "R3";
        if (le == 1 && bitof(mode, 5) == 0) return bitof(mode, 4) ? "R8/R5" : "R7/R5";
        return "R6/R5";
    endfunction

    task automatic chk(string tag, int got, int expv);
        total++;
        if (got != expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, expv);
        end
    endtask

    // reference model state update on the same edge as the design
    always @(posedge clk) begin
        if (rst) begin
            m_mode <= 0; m_base <= 0; m_lat <= 0;
        end else if (wr_en) begin
            if (int'(wr_addr) / 4096 == 5 && bitof(int'(wr_addr), 4) == 1) begin
                if (int'(wr_addr) % 4 == 0) m_mode <= int'(wr_data) & 8'h70;
                if (int'(wr_addr) % 4 == 2) m_base <= int'(wr_data);
            end
            if (int'(wr_addr) >= 32768 && bitof(m_mode, 6) == 1 && bitof(m_mode, 5) == 0)
                m_lat <= int'(wr_data) % 4;
        end
    end

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            chk({tag_of(m_mode, 1), " latch-on addr"}, int'(addr_l),
                exp_addr(m_mode, m_base, int'(inner_bank), int'(ppu_a), m_lat, 1));
            chk({tag_of(m_mode, 0), " latch-off addr"}, int'(addr_n),
                exp_addr(m_mode, m_base, int'(inner_bank), int'(ppu_a), 0, 0));
            chk("R10 latch-on ram_sel", int'(ram_l), exp_ram(m_mode, 1));
            chk("R10 latch-off ram_sel", int'(ram_n), exp_ram(m_mode, 0));
        end
    end

    task automatic cpu_wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 16'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 16'h0000;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        inner_bank = 8'hA5;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(1);
        // R1: reset state
        chk("R1 reset addr", int'(addr_l), 'h0A5);
        chk("R1 reset ram_sel", int'(ram_l), 0);

        // R3: base B7 -> top bits 101
        cpu_wr('h5012, 'hB7);
        for (int i = 0; i < 256; i += 37) begin
            @(negedge clk); inner_bank = 8'(i);
        end
        inner_bank = 8'h3C; idle(1);
        chk("R3 explicit", int'(addr_l), 'h53C);

        // R2: ignored writes (select bit clear, wrong low bits)
        cpu_wr('h5002, 'hFF);
        cpu_wr('h5013, 'hFF);
        cpu_wr('h5011, 'hFF);
        cpu_wr('h4012, 'hFF);
        idle(1);
        chk("R2 ignored writes addr", int'(addr_l), 'h53C);
        chk("R2 ignored writes ram", int'(ram_n), 0);
        // R2: aliased address with extra bits set still hits
        cpu_wr('h5FFE, 'hB7);
        idle(1);
        chk("R2 alias base write", int'(addr_l), 'h53C);

        // R4: half outer window
        cpu_wr('h5010, 'h10);
        inner_bank = 8'hFF; idle(1);
        chk("R4 explicit", int'(addr_l), 'h5FF);

        // R11: combinational path, no edge
        @(negedge clk); inner_bank = 8'h01; #1;
        chk("R11 inner same cycle", int'(addr_l), 'h581);

        // R7: pass-through, latch 32K
        cpu_wr('h5010, 'h40);
        cpu_wr('h8000, 'h03);
        for (int p = 0; p < 8; p++) begin
            @(negedge clk); ppu_a = 3'(p);
        end
        ppu_a = 3'd5; idle(1);
        chk("R7 explicit", int'(addr_l), ('hB4 + 3) * 8 + 5);
        chk("R6 latch-off explicit", int'(addr_n), 'hB7 * 8 + 5);
        @(negedge clk); ppu_a = 3'd2; #1;
        chk("R11 ppu same cycle", int'(addr_l), ('hB4 + 3) * 8 + 2);

        // R8: 16K window
        cpu_wr('h5010, 'h50);
        cpu_wr('hFFFF, 'h02);
        idle(1);
        chk("R8 explicit", int'(addr_l), ('hB6 + 0) * 8 + 2);

        // R9: latch disabled by bit 5; writes ignored
        cpu_wr('h5010, 'h60);
        cpu_wr('hC000, 'h01);
        idle(1);
        chk("R6 bit5 set addr", int'(addr_l), 'hB7 * 8 + 2);
        cpu_wr('h5010, 'h40);
        idle(1);
        chk("R9 latch held", int'(addr_l), ('hB4 + 2) * 8 + 2);
        // R9: inner mode write ignored
        cpu_wr('h5010, 'h00);
        cpu_wr('h9FFF, 'h01);
        cpu_wr('h5010, 'h40);
        idle(1);
        chk("R9 latch held inner", int'(addr_l), ('hB4 + 2) * 8 + 2);

        // R10: chip select
        cpu_wr('h5010, 'h20);
        idle(1);
        chk("R10 latch-on ram", int'(ram_l), 1);
        chk("R10 latch-off ram", int'(ram_n), 1);
        cpu_wr('h5010, 'h60);
        idle(1);
        chk("R10 direct latch-on ram", int'(ram_l), 0);
        chk("R10 direct latch-off ram", int'(ram_n), 1);

        // mixed stimulus against the model
        for (int k = 0; k < 400; k++) begin
            int sel;
            sel = $urandom_range(0, 5);
            inner_bank = 8'($urandom);
            ppu_a = 3'($urandom);
            case (sel)
                0: cpu_wr('h5010, int'($urandom) & 'hFF);
                1: cpu_wr('h5012, int'($urandom) & 'hFF);
                2: cpu_wr('h8000 + int'($urandom_range(0, 'h7FFF)), int'($urandom) & 'hFF);
                3: cpu_wr('h5000 + int'($urandom_range(0, 'hFFF)), int'($urandom) & 'hFF);
                default: idle(1);
            endcase
        end

        idle(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule